// File: doc/BRIEF.md
# Two-Port Memory with Address-Collision Busy Arbitration

This block is a small two-port memory with a left and a right port. Each port has its own enable, write strobe, address, write data, read data, an active-low busy output and a busy input. Both ports work on the array independently. The only case that needs handling is when both ports are enabled on the same address in the same cycle. The arbiter then lets one side through and flags the other as busy. Arbitration looks only at enables and addresses. The write strobe plays no part in who wins, so two reads of the same address also raise busy.

A strap input sets the role of the busy pins. With the strap high (master), the block arbitrates and drives a registered busy to the losing side. With the strap low (slave), the block does no arbitration. Its busy outputs stay inactive, and each port's busy input acts only as a write inhibit for that port. Every write is captured in one cycle and committed on the next clock edge. The busy or inhibit decision for that write has therefore settled before the memory is touched, and a glitch on the inhibit cannot corrupt data.

Top module: `dpb_busy_arb`

## Requirements
- R1: In master mode (`master_sel`=1), when both enables are high and both addresses are equal, exactly one busy output is low after the next clock edge. This holds for any mix of write strobes, including two reads.
- R2: In master mode, if neither port held that address with its enable high in the previous cycle, the left port wins. `rt_busy_n` goes low and `lt_busy_n` stays high.
- R3: A port that was already enabled on an address keeps priority over a newcomer to that address. It keeps priority while its enable stays high and its address is unchanged. When the owner drops its enable or moves to another address, the other port's busy returns high after the next edge.
- R4: Accesses to different addresses raise no busy, and writes from both ports in the same cycle both land.
- R5: A port with its enable low never causes busy on the other port.
- R6: In master mode, a write from the losing port is discarded and the winner's write lands. The busy inputs have no effect in master mode.
- R7: In slave mode (`master_sel`=0), both busy outputs stay high and there is no arbitration. A write is discarded when that port's busy input is low in the cycle the write is presented.
- R8: A busy input held low permanently in slave mode prevents every write from that port, while the other port keeps writing normally.
- R9: A port that is flagged busy still gets read data. The read data is registered: an enabled port presents the array word at its address after the next edge, and the read data holds while the enable is low.
- R10: A write presented in cycle t is committed on the edge that ends cycle t+1. A read sampled on that same edge returns the old word. During reset, read data is 0, busy outputs are high, and the array is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_sel | input | 1 | Strap: 1 = arbitrate and drive busy, 0 = busy inputs inhibit writes |
| lt_en | input | 1 | Left port enable |
| lt_we | input | 1 | Left port write strobe |
| lt_addr | input | AW | Left port address |
| lt_wdata | input | DW | Left port write data |
| lt_rdata | output | DW | Left port registered read data |
| lt_busy_in | input | 1 | Left write inhibit, active low, used in slave mode |
| lt_busy_n | output | 1 | Left busy, active low, driven in master mode |
| rt_en | input | 1 | Right port enable |
| rt_we | input | 1 | Right port write strobe |
| rt_addr | input | AW | Right port address |
| rt_wdata | input | DW | Right port write data |
| rt_rdata | output | DW | Right port registered read data |
| rt_busy_in | input | 1 | Right write inhibit, active low, used in slave mode |
| rt_busy_n | output | 1 | Right busy, active low, driven in master mode |

## Verification
The bench builds the block with AW=3 and DW=8, which gives an eight-word array. With so few addresses, the random traffic phase produces same-address collisions, ownership hand-offs and read-against-write clashes every few cycles, alongside the directed same-cycle, staggered, slave-inhibit and tied-low sequences. The 8-bit data width lets every write carry a distinct value, so a dropped or misdirected write shows up in later reads.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
   localparam int PORTS = 2;
   localparam int PORT_LT = 0;
   localparam int PORT_RT = 1;

   typedef enum logic [1:0] {
      GRANT_NONE = 2'd0,
      GRANT_LT   = 2'd1,
      GRANT_RT   = 2'd2
   } grant_e;
endpackage

// File: rtl/dpb_collide.sv
// Same-address detection and registered tie-break between the two ports.
module dpb_collide
   import dpb_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lt_en,
   input  logic [AW-1:0] lt_addr,
   input  logic          rt_en,
   input  logic [AW-1:0] rt_addr,
   output logic          lt_lose,
   output logic          rt_lose
);
   logic          prv_lt_en, prv_rt_en;
   logic [AW-1:0] prv_lt_addr, prv_rt_addr;
   grant_e        last_grant, grant_nx;
   logic          hit, lt_held, rt_held;

   assign hit     = lt_en && rt_en && (lt_addr == rt_addr);
   assign lt_held = lt_en && prv_lt_en && (lt_addr == prv_lt_addr);
   assign rt_held = rt_en && prv_rt_en && (rt_addr == prv_rt_addr);

   always_comb begin
      grant_nx = GRANT_NONE;
      if (hit) begin
         if (last_grant == GRANT_LT && lt_held)      grant_nx = GRANT_LT;
         else if (last_grant == GRANT_RT && rt_held) grant_nx = GRANT_RT;
         else if (rt_held && !lt_held)               grant_nx = GRANT_RT;
         else                                        grant_nx = GRANT_LT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_grant  <= GRANT_NONE;
         lt_lose     <= 1'b0;
         rt_lose     <= 1'b0;
         prv_lt_en   <= 1'b0;
         prv_rt_en   <= 1'b0;
         prv_lt_addr <= '0;
         prv_rt_addr <= '0;
      end else begin
         last_grant  <= grant_nx;
         lt_lose     <= (grant_nx == GRANT_RT);
         rt_lose     <= (grant_nx == GRANT_LT);
         prv_lt_en   <= lt_en;
         prv_rt_en   <= rt_en;
         prv_lt_addr <= lt_addr;
         prv_rt_addr <= rt_addr;
      end
   end
endmodule

// File: rtl/dpb_wport.sv
// Per-port write capture; commits one edge later, gated by a settled inhibit.
module dpb_wport #(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic          master,
   input  logic          lose,
   input  logic          busy_in,
   output logic          cmt,
   output logic [AW-1:0] cmt_addr,
   output logic [DW-1:0] cmt_data
);
   logic p_wr, p_mst, p_sinh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_wr     <= 1'b0;
         p_mst    <= 1'b0;
         p_sinh   <= 1'b0;
         cmt_addr <= '0;
         cmt_data <= '0;
      end else begin
         p_wr     <= en && we;
         p_mst    <= master;
         p_sinh   <= !busy_in;
         cmt_addr <= addr;
         cmt_data <= wdata;
      end
   end

   assign cmt = p_wr && !(p_mst ? lose : p_sinh);
endmodule

// File: rtl/dpb_array.sv
// Register-array storage with registered reads and per-port write commits.
module dpb_array
   import dpb_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en    [PORTS],
   input  logic [AW-1:0] rd_addr  [PORTS],
   input  logic          cmt      [PORTS],
   input  logic [AW-1:0] cmt_addr [PORTS],
   input  logic [DW-1:0] cmt_data [PORTS],
   output logic [DW-1:0] rdata    [PORTS]
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         for (int p = 0; p < PORTS; p++) rdata[p] <= '0;
      end else begin
         for (int p = 0; p < PORTS; p++)
            if (rd_en[p]) rdata[p] <= mem[rd_addr[p]];
         // lower index last, so the left port prevails on a shared address
         for (int p = PORTS - 1; p >= 0; p--)
            if (cmt[p]) mem[cmt_addr[p]] <= cmt_data[p];
      end
   end
endmodule

// File: rtl/dpb_busy_arb.sv
module dpb_busy_arb
   import dpb_pkg::*;
#(
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          master_sel,
   input  logic          lt_en,
   input  logic          lt_we,
   input  logic [AW-1:0] lt_addr,
   input  logic [DW-1:0] lt_wdata,
   output logic [DW-1:0] lt_rdata,
   input  logic          lt_busy_in,
   output logic          lt_busy_n,
   input  logic          rt_en,
   input  logic          rt_we,
   input  logic [AW-1:0] rt_addr,
   input  logic [DW-1:0] rt_wdata,
   output logic [DW-1:0] rt_rdata,
   input  logic          rt_busy_in,
   output logic          rt_busy_n
);
   if (AW < 1 || AW > 10) begin : g_bad_aw
      $error("dpb_busy_arb: AW must lie in 1..10");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dpb_busy_arb: DW must be at least 1");
   end

   logic          en_v    [PORTS];
   logic          we_v    [PORTS];
   logic [AW-1:0] addr_v  [PORTS];
   logic [DW-1:0] wdata_v [PORTS];
   logic          bin_v   [PORTS];
   logic          lose_v  [PORTS];
   logic          bsy_v   [PORTS];
   logic          cmt_v   [PORTS];
   logic [AW-1:0] caddr_v [PORTS];
   logic [DW-1:0] cdata_v [PORTS];
   logic [DW-1:0] rd_v    [PORTS];

   assign en_v[PORT_LT]    = lt_en;
   assign en_v[PORT_RT]    = rt_en;
   assign we_v[PORT_LT]    = lt_we;
   assign we_v[PORT_RT]    = rt_we;
   assign addr_v[PORT_LT]  = lt_addr;
   assign addr_v[PORT_RT]  = rt_addr;
   assign wdata_v[PORT_LT] = lt_wdata;
   assign wdata_v[PORT_RT] = rt_wdata;
   assign bin_v[PORT_LT]   = lt_busy_in;
   assign bin_v[PORT_RT]   = rt_busy_in;

   dpb_collide #(.AW(AW)) u_collide (
      .clk     (clk),
      .rst_n   (rst_n),
      .lt_en   (lt_en),
      .lt_addr (lt_addr),
      .rt_en   (rt_en),
      .rt_addr (rt_addr),
      .lt_lose (lose_v[PORT_LT]),
      .rt_lose (lose_v[PORT_RT])
   );

   for (genvar p = 0; p < PORTS; p++) begin : g_port
      dpb_wport #(.AW(AW), .DW(DW)) u_wport (
         .clk      (clk),
         .rst_n    (rst_n),
         .en       (en_v[p]),
         .we       (we_v[p]),
         .addr     (addr_v[p]),
         .wdata    (wdata_v[p]),
         .master   (master_sel),
         .lose     (lose_v[p]),
         .busy_in  (bin_v[p]),
         .cmt      (cmt_v[p]),
         .cmt_addr (caddr_v[p]),
         .cmt_data (cdata_v[p])
      );
      assign bsy_v[p] = ~(master_sel & lose_v[p]);
   end

   dpb_array #(.AW(AW), .DW(DW)) u_array (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (en_v),
      .rd_addr  (addr_v),
      .cmt      (cmt_v),
      .cmt_addr (caddr_v),
      .cmt_data (cdata_v),
      .rdata    (rd_v)
   );

   assign lt_rdata  = rd_v[PORT_LT];
   assign rt_rdata  = rd_v[PORT_RT];
   assign lt_busy_n = bsy_v[PORT_LT];
   assign rt_busy_n = bsy_v[PORT_RT];
endmodule

module dpb_arb_chk #(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          master_sel,
   input logic          lt_en,
   input logic [AW-1:0] lt_addr,
   input logic          lt_busy_n,
   input logic          rt_en,
   input logic [AW-1:0] rt_addr,
   input logic          rt_busy_n
);
   // R1
   busy_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_busy_n || rt_busy_n));

   // R1
   collision_flags_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (master_sel && lt_en && rt_en && lt_addr == rt_addr)
      |=> (!master_sel || (lt_busy_n != rt_busy_n)));

   // R4
   distinct_addr_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lt_en && rt_en && lt_addr != rt_addr) |=> (lt_busy_n && rt_busy_n));

   // R5
   idle_right_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rt_en) |=> lt_busy_n);

   // R5
   idle_left_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lt_en) |=> rt_busy_n);
endmodule

bind dpb_busy_arb dpb_arb_chk #(.AW(AW)) u_arb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .master_sel (master_sel),
   .lt_en      (lt_en),
   .lt_addr    (lt_addr),
   .lt_busy_n  (lt_busy_n),
   .rt_en      (rt_en),
   .rt_addr    (rt_addr),
   .rt_busy_n  (rt_busy_n)
);

// File: tb/dpb_busy_arb_test.sv
`timescale 1ns/1ps
module dpb_busy_arb_test;
   localparam int AW = 3;
   localparam int DW = 8;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0, ms = 1'b1;
   logic lt_en = 0, lt_we = 0, rt_en = 0, rt_we = 0;
   logic [AW-1:0] lt_addr = '0, rt_addr = '0;
   logic [DW-1:0] lt_wdata = '0, rt_wdata = '0;
   logic lt_bin = 1'b1, rt_bin = 1'b1;
   logic [DW-1:0] lt_rdata, rt_rdata;
   logic lt_busy_n, rt_busy_n;

   always #2 clk = ~clk;

   dpb_busy_arb #(.AW(AW), .DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .master_sel(ms),
      .lt_en(lt_en), .lt_we(lt_we), .lt_addr(lt_addr), .lt_wdata(lt_wdata),
      .lt_rdata(lt_rdata), .lt_busy_in(lt_bin), .lt_busy_n(lt_busy_n),
      .rt_en(rt_en), .rt_we(rt_we), .rt_addr(rt_addr), .rt_wdata(rt_wdata),
      .rt_rdata(rt_rdata), .rt_busy_in(rt_bin), .rt_busy_n(rt_busy_n)
   );

   int n_run = 0, n_fail = 0;
   string tag = "R10";
   bit done = 0;

   // behavioural reference state
   int mem_m [DEPTH];
   int rdl_m = 0, rdr_m = 0, lastw = 0;
   bit lose_l = 0, lose_r = 0;
   bit pl_en = 0, pr_en = 0;
   int pl_a = 0, pr_a = 0;
   bit pw_l = 0, pw_r = 0, pinh_l = 0, pinh_r = 0;
   int pa_l = 0, pa_r = 0, pd_l = 0, pd_r = 0;

   task automatic cmp(input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_edge();
      bit hit, lh, rh;
      int w;
      if (lt_en) rdl_m = mem_m[lt_addr];
      if (rt_en) rdr_m = mem_m[rt_addr];
      if (pw_r && !pinh_r) mem_m[pa_r] = pd_r;
      if (pw_l && !pinh_l) mem_m[pa_l] = pd_l;
      hit = lt_en && rt_en && (lt_addr == rt_addr);
      lh  = lt_en && pl_en && (int'(lt_addr) == pl_a);
      rh  = rt_en && pr_en && (int'(rt_addr) == pr_a);
      w = 0;
      if (hit) begin
         if (lastw == 1 && lh) w = 1;
         else if (lastw == 2 && rh) w = 2;
         else if (rh && !lh) w = 2;
         else w = 1;
      end
      lastw = w;
      lose_l = (w == 2);
      lose_r = (w == 1);
      pl_en = lt_en; pl_a = lt_addr; pr_en = rt_en; pr_a = rt_addr;
      pw_l = lt_en && lt_we; pa_l = lt_addr; pd_l = lt_wdata;
      pw_r = rt_en && rt_we; pa_r = rt_addr; pd_r = rt_wdata;
      pinh_l = ms ? lose_l : !lt_bin;
      pinh_r = ms ? lose_r : !rt_bin;
   endtask

   task automatic compare_all();
      cmp("lt_rdata", lt_rdata, rdl_m);
      cmp("rt_rdata", rt_rdata, rdr_m);
      cmp("lt_busy_n", lt_busy_n, ms ? !lose_l : 1);
      cmp("rt_busy_n", rt_busy_n, ms ? !lose_r : 1);
   endtask

   task automatic step(input bit le, input bit lw, input int la, input int ld,
                       input bit re, input bit rw, input int ra, input int rd);
      lt_en = le; lt_we = lw; lt_addr = la[AW-1:0]; lt_wdata = ld[DW-1:0];
      rt_en = re; rt_we = rw; rt_addr = ra[AW-1:0]; rt_wdata = rd[DW-1:0];
      @(posedge clk);
      model_edge();
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem_m[i] = 0;
      repeat (3) @(negedge clk);
      tag = "R10";
      cmp("reset lt_rdata", lt_rdata, 0);
      cmp("reset rt_rdata", rt_rdata, 0);
      cmp("reset lt_busy_n", lt_busy_n, 1);
      cmp("reset rt_busy_n", rt_busy_n, 1);
      rst_n = 1'b1;

      // R4: distinct addresses, both writes land, no busy
      tag = "R4";
      step(1, 1, 1, 'h11, 1, 1, 2, 'h22);
      cmp("no busy lt", lt_busy_n, 1);
      step(0, 0, 0, 0, 0, 0, 0, 0);
      step(1, 0, 2, 0, 1, 0, 1, 0);
      cmp("cross read lt", lt_rdata, 'h22);
      cmp("cross read rt", rt_rdata, 'h11);

      // R10: write committed one edge late, same-edge read sees old word
      tag = "R10";
      step(1, 1, 4, 'h44, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0, 4, 0);
      cmp("old word", rt_rdata, 0);
      step(0, 0, 0, 0, 1, 0, 4, 0);
      cmp("new word", rt_rdata, 'h44);

      // R2: fresh same-cycle write collision, left wins
      tag = "R2";
      step(1, 1, 3, 'hA1, 1, 1, 3, 'hB2);
      cmp("winner lt_busy_n", lt_busy_n, 1);
      cmp("loser rt_busy_n", rt_busy_n, 0);
      tag = "R6";
      idle(1);
      step(1, 0, 3, 0, 0, 0, 0, 0);
      cmp("left data kept", lt_rdata, 'hA1);

      // R1: two reads of one address still flag busy
      tag = "R1";
      step(1, 0, 5, 0, 1, 0, 5, 0);
      cmp("read-read busy", rt_busy_n, 0);
      idle(1);

      // R9: loser reads during a read/write clash
      tag = "R9";
      step(1, 1, 4, 'h55, 1, 0, 4, 0);
      cmp("busy reader data", rt_rdata, 'h44);
      cmp("reader busy", rt_busy_n, 0);
      idle(2);

      // R3: staggered collision, right owns address 6
      tag = "R3";
      step(0, 0, 0, 0, 1, 1, 6, 'h60);
      step(1, 1, 6, 'hE1, 1, 1, 6, 'h61);
      cmp("newcomer busy", lt_busy_n, 0);
      step(1, 1, 6, 'hE2, 1, 0, 6, 0);
      cmp("owner kept", lt_busy_n, 0);
      step(1, 1, 6, 'hE3, 0, 0, 0, 0);
      cmp("release", lt_busy_n, 1);
      idle(1);
      step(0, 0, 0, 0, 1, 0, 6, 0);
      cmp("after release", rt_rdata, 'hE3);
      // owner moves away
      step(1, 0, 7, 0, 0, 0, 0, 0);
      step(1, 0, 7, 0, 1, 0, 7, 0);
      cmp("newcomer rt busy", rt_busy_n, 0);
      step(1, 0, 1, 0, 1, 0, 7, 0);
      cmp("moved owner", rt_busy_n, 1);

      // R5: disabled port with matching address raises nothing
      tag = "R5";
      step(1, 1, 2, 'h25, 0, 1, 2, 'h99);
      cmp("no busy", lt_busy_n, 1);
      idle(1);

      // R6: busy inputs ignored in master mode
      tag = "R6";
      lt_bin = 0; rt_bin = 0;
      step(1, 1, 0, 'h0C, 0, 0, 0, 0);
      idle(1);
      step(1, 0, 0, 0, 0, 0, 0, 0);
      cmp("master ignores inhibit", lt_rdata, 'h0C);
      lt_bin = 1; rt_bin = 1;

      // R7: slave mode, no arbitration, inhibit by busy input
      tag = "R7";
      ms = 1'b0;
      step(1, 0, 3, 0, 1, 1, 3, 'h77);
      cmp("slave no busy", rt_busy_n, 1);
      rt_bin = 0;
      step(0, 0, 0, 0, 1, 1, 3, 'h78);
      rt_bin = 1;
      idle(1);
      step(1, 0, 3, 0, 0, 0, 0, 0);
      cmp("inhibited write", lt_rdata, 'h77);

      // R8: tied-low busy input blocks every right write
      tag = "R8";
      rt_bin = 0;
      for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 0, 1, 1, i, 'hF0 + i);
      idle(1);
      for (int i = 0; i < DEPTH; i++) step(1, 1, i, 'h30 + i, 1, 0, i, 0);
      idle(1);
      step(0, 0, 0, 0, 1, 0, 5, 0);
      cmp("left still writes", rt_rdata, 'h35);

      // random traffic in both modes
      for (int i = 0; i < 600; i++) begin
         ms = (i < 400);
         tag = ms ? "R1" : "R7";
         lt_bin = ($urandom % 4) != 0;
         rt_bin = ms ? 1'b1 : 1'b0;
         step($urandom % 4 != 0, $urandom % 2, $urandom % DEPTH, $urandom % 256,
              $urandom % 4 != 0, $urandom % 2, $urandom % DEPTH, $urandom % 256);
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule